// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped periodic timer that raises a periodic interrupt. The system clock is divided by a fixed factor of 16 to form a tick. Each tick advances a 20-bit interval counter. When the counter has covered the programmed period, it returns to zero. At that point a 12-bit elapsed-period count goes up by one and a status flag is set.

Software programs the period (desired ticks minus one) and the two enable bits through a small register bus. It reads the counters through one of two windows. The acknowledging window clears the flag and the elapsed-period count. The image window only observes. Clearing the run enable does not stop the counter at once: it finishes the period in progress and then rests at zero.

Read data is registered and appears on the clock after the read strobe. The interrupt output is registered and follows its condition one clock later.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset, the control word, status flag, interval count and period count all read zero, and the interrupt is low.
- R2: The control register at offset 0x00 keeps bits 19:0 (period), bit 24 (run enable) and bit 25 (interrupt enable). Its other bits read back as zero.
- R3: While running, the interval count advances by one every 16 system clocks.
- R4: A period lasts the programmed value plus one ticks. On the tick after the count equals the period, the count returns to 0, the period count increments and status bit 0 at offset 0x04 sets.
- R5: A read at offset 0x08 returns the period count in bits 31:20 and the interval count in bits 19:0. The same read clears the status flag and the period count.
- R6: A read at offset 0x0C returns the same fields as offset 0x08 and changes neither the flag nor the period count.
- R7: After the run enable is cleared, counting continues to the end of the current period. The interval count then stays at zero.
- R8: The interrupt is high exactly when the interrupt enable and the status flag were both set on the previous clock. The counter runs whether or not the interrupt is enabled.
- R9: The period count saturates at 4095.
- R10: Writes to offsets 0x04, 0x08 and 0x0C have no effect, and a read of any other unmapped offset returns zero.
- R11: Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven with a period of zero, where every tick ends a period. It is also driven with short periods stopped mid-interval, and with a long single-tick run. Together these separate an off-by-one in period length from an error in the divide-by-16, and a wrong split between period count and interval count from a wrong wrap point. The saturating run shows whether the period count wraps past 4095. Paired image and acknowledging reads around a pending event show whether each window clears what it should.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_STAT   = 'h04;
  localparam int unsigned OFS_ACKVAL = 'h08;
  localparam int unsigned OFS_IMAGE  = 'h0C;
  localparam int unsigned BIT_RUN    = 24;
  localparam int unsigned BIT_IEN    = 25;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;

  assign tick = active && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) phase <= '0;
    else if (tick)      phase <= '0;
    else                phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned PCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  period,
  input  logic              ack,
  output logic [CNT_W-1:0]  ivl,
  output logic [PCNT_W-1:0] pcnt,
  output logic              flag
);
  localparam logic [PCNT_W-1:0] PMAX = '1;

  logic wrap;
  assign wrap = tick && (ivl >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl  <= '0;
      pcnt <= '0;
      flag <= 1'b0;
    end else begin
      if (tick) ivl <= wrap ? '0 : ivl + 1'b1;
      if (wrap) begin
        flag <= 1'b1;
        if (ack)              pcnt <= PCNT_W'(1);
        else if (pcnt != PMAX) pcnt <= pcnt + 1'b1;
      end else if (ack) begin
        flag <= 1'b0;
        pcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned PCNT_W = 12,
  parameter int unsigned DIV    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import ivt_pkg::*;

  localparam int unsigned PAD_W = DATA_W - CNT_W - PCNT_W;

  logic [CNT_W-1:0]  period;
  logic              run_en;
  logic              irq_en;
  logic              tick;
  logic              ack;
  logic [CNT_W-1:0]  ivl;
  logic [PCNT_W-1:0] pcnt;
  logic              flag;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] cnt_view;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      run_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (bus_we && bus_addr == ADDR_W'(OFS_CTRL)) begin
      period <= bus_wdata[CNT_W-1:0];
      run_en <= bus_wdata[BIT_RUN];
      irq_en <= bus_wdata[BIT_IEN];
    end
  end

  assign ack = bus_re && (bus_addr == ADDR_W'(OFS_ACKVAL));

  ivt_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .active (run_en || (ivl != '0)),
    .tick   (tick)
  );

  ivt_counter #(.CNT_W(CNT_W), .PCNT_W(PCNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .period (period),
    .ack    (ack),
    .ivl    (ivl),
    .pcnt   (pcnt),
    .flag   (flag)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_view = {pcnt, {PAD_W{1'b0}}, ivl};
    end else begin : g_nopad
      assign cnt_view = {pcnt, ivl};
    end
  endgenerate

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CNT_W-1:0] = period;
    ctrl_view[BIT_RUN]   = run_en;
    ctrl_view[BIT_IEN]   = irq_en;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   rd_mux = ctrl_view;
      ADDR_W'(OFS_STAT):   rd_mux = DATA_W'(flag);
      ADDR_W'(OFS_ACKVAL),
      ADDR_W'(OFS_IMAGE):  rd_mux = cnt_view;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_mux;
      irq <= irq_en && flag;
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned PCNT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic              irq,
  input logic              run_en,
  input logic              irq_en,
  input logic [CNT_W-1:0]  ivl,
  input logic [PCNT_W-1:0] pcnt,
  input logic              flag
);
  logic ack_rd;
  logic ctrl_wr;
  assign ack_rd  = bus_re && (bus_addr == ADDR_W'('h08));
  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'('h00));

  // R3
  ivl_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ivl != $past(ivl)) |-> (ivl == $past(ivl) + 1'b1 || ivl == '0));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !ack_rd) |=> flag);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && ivl == '0 && !ctrl_wr) |=> (ivl == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(flag) && $past(irq_en)));

  // R9
  pcnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (pcnt == '1 && !ack_rd) |=> (pcnt == '1));
endmodule

bind interval_timer interval_timer_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PCNT_W(PCNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .irq(irq), .run_en(run_en), .irq_en(irq_en),
  .ivl(ivl), .pcnt(pcnt), .flag(flag)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int NV = 5;
  localparam logic [19:0] V_PER [NV] = '{20'd0, 20'd3, 20'd9, 20'd4, 20'd1};
  localparam int          V_TCK [NV] = '{5, 10, 4, 17, 6};
  localparam logic [11:0] V_PC  [NV] = '{12'd5, 12'd2, 12'd0, 12'd3, 12'd3};
  localparam logic [19:0] V_IV  [NV] = '{20'd0, 20'd2, 20'd4, 20'd2, 20'd0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(posedge clk); @(negedge clk); d = bus_rdata; bus_re = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_reg(5'h00, rd); chk("R1 ctrl", rd, 32'h0);
    rd_reg(5'h04, rd); chk("R1 status", rd, 32'h0);
    rd_reg(5'h0C, rd); chk("R1 image", rd, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 control readback, R10 ignored writes / unmapped
    wr(5'h00, 32'hFEF0_0005);
    rd_reg(5'h00, rd); chk("R2 ctrl bits", rd, 32'h0200_0005);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_reg(5'h00, rd); chk("R10 ctrl untouched", rd, 32'h0200_0005);
    rd_reg(5'h04, rd); chk("R10 status untouched", rd, 32'h0);
    rd_reg(5'h0C, rd); chk("R10 counts untouched", rd, 32'h0);
    rd_reg(5'h14, rd); chk("R10 unmapped", rd, 32'h0);

    // R3 R4 R11 vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(5'h00, {12'h010, V_PER[i]});
      repeat (V_TCK[i] * 16) @(posedge clk);
      rd_reg(5'h0C, rd);
      chk("R3/R4 vector", rd, {V_PC[i], V_IV[i]});
    end

    // R5 R6 acknowledge versus image
    do_reset();
    wr(5'h00, 32'h0100_0003);
    repeat (9 * 16) @(posedge clk);
    rd_reg(5'h0C, rd); chk("R6 image first", rd, {12'd2, 20'd1});
    rd_reg(5'h0C, rd); chk("R6 image again", rd, {12'd2, 20'd1});
    rd_reg(5'h04, rd); chk("R6 flag kept", rd, 32'h1);
    rd_reg(5'h08, rd); chk("R5 ack value", rd, {12'd2, 20'd1});
    rd_reg(5'h04, rd); chk("R5 flag cleared", rd, 32'h0);
    rd_reg(5'h0C, rd); chk("R5 count cleared", rd, {12'd0, 20'd1});

    // R8 interrupt enabled
    do_reset();
    wr(5'h00, 32'h0300_0000);
    repeat (40) @(posedge clk);
    @(negedge clk); chk("R8 irq on", {31'h0, irq}, 32'h1);
    rd_reg(5'h08, rd);
    @(posedge clk); @(negedge clk);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R8 interrupt disabled, timer still runs
    do_reset();
    wr(5'h00, 32'h0100_0000);
    repeat (40) @(posedge clk);
    @(negedge clk); chk("R8 irq masked", {31'h0, irq}, 32'h0);
    rd_reg(5'h04, rd); chk("R8 runs masked", rd, 32'h1);

    // R7 disable finishes period
    do_reset();
    wr(5'h00, 32'h0100_0007);
    repeat (48) @(posedge clk);
    wr(5'h00, 32'h0000_0007);
    repeat (300) @(posedge clk);
    rd_reg(5'h0C, rd); chk("R7 stop at end", rd, {12'd1, 20'd0});
    repeat (200) @(posedge clk);
    rd_reg(5'h0C, rd); chk("R7 stays stopped", rd, {12'd1, 20'd0});

    // R9 saturation
    do_reset();
    wr(5'h00, 32'h0100_0000);
    repeat (4100 * 16) @(posedge clk);
    rd_reg(5'h0C, rd); chk("R9 saturate", rd, {12'hFFF, 20'd0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule